// File: doc/BRIEF.md
# Floating-Point Status Word Register

This block holds the 16-bit status word of a stack-based floating-point unit. Each instruction may report new exceptions, a stack fault, a condition-code update of a given kind and a new stack-top value. The exception flags are sticky: they collect reports until software clears, reinitialises, saves or reloads the word. The summary bit and its legacy copy are not stored. They are derived at all times from the flags and the 6-bit exception mask of the control word, and they drive the error request to the handler.

The condition codes carry different meanings depending on the kind of instruction that reports them: stack fault direction, rounding direction, partial-remainder progress and quotient bits, trig range check, or operand sign. A command input selects one of five modes for the register in a cycle: idle, clear, init, save or load. Codes 5 to 7 act as idle. The command is applied first. The reports, the condition-code update and the stack-top write of the same cycle are then applied on top of its result.

Top module: `fpsw_reg`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `status_word` is 16'h0000 and `err_req` is 0.
- R2: The exception flags sit at word bits 0..5 in the order invalid, denormal, divide-by-zero, overflow, underflow, precision, and the stack-fault flag sits at bit 6. At each clock edge, `exc_flags` and `exc_sf` are ORed into them, and a flag that is set stays set while `cmd` is idle.
- R3: Bit 7 (summary) is 1 exactly when some flag in bits 0..5 is set with its `exc_mask` bit at 0. Bit 15 and `err_req` always equal bit 7. A mask change shows in the same cycle, with no clock edge needed.
- R4: `cmd`=1 (clear) zeroes bits 0..6 and leaves the condition codes and stack top unchanged. A report in the same cycle is ORed in after the clear.
- R5: `cmd`=2 (init) and `cmd`=3 (save) zero the whole word. Reports, condition-code updates and stack-top writes in the same cycle apply after the clear.
- R6: `cmd`=4 (load) overwrites flags, stack fault, condition codes and stack top from `load_word` at the same bit positions. The summary bits 7 and 15 of `load_word` are ignored and recomputed.
- R7: `cc_kind`=1 (stack fault) sets C1 (bit 9) to `cc_info[0]`, where 1 means overflow and 0 means underflow. The other condition codes are unchanged.
- R8: `cc_kind`=2 (rounding) sets C1 to `cc_info[0]`, where 1 means the last rounding went upward.
- R9: `cc_kind`=3 (partial remainder): if `cc_info[3]`=1, C2 (bit 10) becomes 1 and C0, C1, C3 keep their values. Otherwise C2 becomes 0, C0 (bit 8) takes `cc_info[2]`, C3 (bit 14) takes `cc_info[1]`, and C1 takes `cc_info[0]`.
- R10: `cc_kind`=4 (trig range) sets C2 to `cc_info[0]`, where 1 means the operand magnitude is beyond 2^63. The other condition codes are unchanged.
- R11: `cc_kind`=5 (classify) sets C1 to the operand sign `cc_info[0]`. Kinds 0, 6 and 7 leave the condition codes unchanged.
- R12: `top_we`=1 writes `top_in` into the stack-top field, bits 13..11. Otherwise that field changes only by init, save or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_flags | input | 6 | Exception report for this cycle, one bit per flag |
| exc_sf | input | 1 | Stack-fault report |
| cc_kind | input | 3 | Kind of condition-code update (0 = none) |
| cc_info | input | 4 | Payload of the condition-code update |
| top_we | input | 1 | Stack-top write enable |
| top_in | input | 3 | New stack-top value |
| cmd | input | 3 | Command: 0 idle, 1 clear, 2 init, 3 save, 4 load |
| load_word | input | 16 | Word used by the load command |
| exc_mask | input | 6 | Exception mask bits from the control word |
| status_word | output | 16 | Current status word |
| err_req | output | 1 | Error request to the handler, equal to the summary bit |

## Verification
Stored fields (flags, stack fault, condition codes, stack top) change at the first rising edge after their inputs are driven. The summary bit, bit 15 and `err_req` follow the mask and the flags in the same cycle. The bench drives every input just after a falling edge and checks `err_req` and the whole word 1 ns later, against the old stored state and the new mask. It then checks the stored result at the next falling edge, which is half a period after the capturing rising edge.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
    localparam int NUM_EXC  = 6;
    localparam int TOP_W    = 3;
    localparam int WORD_W   = 16;
    localparam int INFO_W   = 4;
    localparam int SF_BIT   = NUM_EXC;
    localparam int ES_BIT   = NUM_EXC + 1;
    localparam int C0_BIT   = ES_BIT + 1;
    localparam int C1_BIT   = C0_BIT + 1;
    localparam int C2_BIT   = C1_BIT + 1;
    localparam int TOP_LSB  = C2_BIT + 1;
    localparam int C3_BIT   = TOP_LSB + TOP_W;
    localparam int B_BIT    = C3_BIT + 1;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_CLEAR = 3'd1,
        CMD_INIT  = 3'd2,
        CMD_SAVE  = 3'd3,
        CMD_LOAD  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        CC_NONE  = 3'd0,
        CC_STACK = 3'd1,
        CC_ROUND = 3'd2,
        CC_PREM  = 3'd3,
        CC_TRIG  = 3'd4,
        CC_CLASS = 3'd5
    } cc_kind_e;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
        logic c0;
    } cc_t;
endpackage

// File: rtl/fpsw_flags.sv
module fpsw_flags
    import fpsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_e               cmd,
    input  logic [NUM_EXC-1:0] exc_in,
    input  logic               sf_in,
    input  logic [NUM_EXC-1:0] ld_exc,
    input  logic               ld_sf,
    output logic [NUM_EXC-1:0] exc_q,
    output logic               sf_q
);
    logic [NUM_EXC-1:0] exc_base;
    logic               sf_base;

    // Command first, then the reports of the same cycle are ORed in.
    always_comb begin
        unique case (cmd)
            CMD_CLEAR, CMD_INIT, CMD_SAVE: begin
                exc_base = '0;
                sf_base  = 1'b0;
            end
            CMD_LOAD: begin
                exc_base = ld_exc;
                sf_base  = ld_sf;
            end
            default: begin
                exc_base = exc_q;
                sf_base  = sf_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_q <= '0;
            sf_q  <= 1'b0;
        end else begin
            exc_q <= exc_base | exc_in;
            sf_q  <= sf_base | sf_in;
        end
    end
endmodule

// File: rtl/fpsw_cc.sv
module fpsw_cc
    import fpsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  cc_kind_e          kind,
    input  logic [INFO_W-1:0] info,
    input  cc_t               ld_cc,
    input  logic [TOP_W-1:0]  ld_top,
    input  logic              top_we,
    input  logic [TOP_W-1:0]  top_in,
    output cc_t               cc_q,
    output logic [TOP_W-1:0]  top_q
);
    cc_t              cc_base;
    cc_t              cc_next;
    logic [TOP_W-1:0] top_base;
    logic [TOP_W-1:0] top_next;

    always_comb begin
        unique case (cmd)
            CMD_INIT, CMD_SAVE: begin
                cc_base  = '0;
                top_base = '0;
            end
            CMD_LOAD: begin
                cc_base  = ld_cc;
                top_base = ld_top;
            end
            default: begin
                cc_base  = cc_q;
                top_base = top_q;
            end
        endcase
    end

    // Meaning of the payload depends on the reporting instruction kind.
    always_comb begin
        cc_next = cc_base;
        unique case (kind)
            CC_STACK, CC_ROUND, CC_CLASS: cc_next.c1 = info[0];
            CC_PREM: begin
                if (info[3]) begin
                    cc_next.c2 = 1'b1;
                end else begin
                    cc_next.c2 = 1'b0;
                    cc_next.c0 = info[2];
                    cc_next.c3 = info[1];
                    cc_next.c1 = info[0];
                end
            end
            CC_TRIG: cc_next.c2 = info[0];
            default: cc_next = cc_base;
        endcase
        top_next = top_we ? top_in : top_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q  <= '0;
            top_q <= '0;
        end else begin
            cc_q  <= cc_next;
            top_q <= top_next;
        end
    end
endmodule

// File: rtl/fpsw_summary.sv
module fpsw_summary
    import fpsw_pkg::*;
(
    input  logic [NUM_EXC-1:0] exc_q,
    input  logic [NUM_EXC-1:0] mask,
    output logic               es
);
    logic [NUM_EXC-1:0] live;

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_live
        assign live[i] = exc_q[i] & ~mask[i];
    end

    assign es = |live;
endmodule

// File: rtl/fpsw_reg.sv
module fpsw_reg
    import fpsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXC-1:0]  exc_flags,
    input  logic                exc_sf,
    input  logic [2:0]          cc_kind,
    input  logic [INFO_W-1:0]   cc_info,
    input  logic                top_we,
    input  logic [TOP_W-1:0]    top_in,
    input  logic [2:0]          cmd,
    input  logic [WORD_W-1:0]   load_word,
    input  logic [NUM_EXC-1:0]  exc_mask,
    output logic [WORD_W-1:0]   status_word,
    output logic                err_req
);
    cmd_e               cmd_d;
    cc_kind_e           kind_d;
    logic [NUM_EXC-1:0] exc_q;
    logic               sf_q;
    cc_t                cc_q;
    cc_t                ld_cc;
    logic [TOP_W-1:0]   top_q;
    logic               es;

    assign cmd_d  = cmd_e'(cmd);
    assign kind_d = cc_kind_e'(cc_kind);
    assign ld_cc  = '{c3: load_word[C3_BIT], c2: load_word[C2_BIT],
                      c1: load_word[C1_BIT], c0: load_word[C0_BIT]};

    fpsw_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd_d),
        .exc_in (exc_flags),
        .sf_in  (exc_sf),
        .ld_exc (load_word[NUM_EXC-1:0]),
        .ld_sf  (load_word[SF_BIT]),
        .exc_q  (exc_q),
        .sf_q   (sf_q)
    );

    fpsw_cc u_cc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd_d),
        .kind   (kind_d),
        .info   (cc_info),
        .ld_cc  (ld_cc),
        .ld_top (load_word[TOP_LSB +: TOP_W]),
        .top_we (top_we),
        .top_in (top_in),
        .cc_q   (cc_q),
        .top_q  (top_q)
    );

    fpsw_summary u_sum (
        .exc_q (exc_q),
        .mask  (exc_mask),
        .es    (es)
    );

    always_comb begin
        status_word                      = '0;
        status_word[NUM_EXC-1:0]         = exc_q;
        status_word[SF_BIT]              = sf_q;
        status_word[ES_BIT]              = es;
        status_word[C0_BIT]              = cc_q.c0;
        status_word[C1_BIT]              = cc_q.c1;
        status_word[C2_BIT]              = cc_q.c2;
        status_word[TOP_LSB +: TOP_W]    = top_q;
        status_word[C3_BIT]              = cc_q.c3;
        status_word[B_BIT]               = es;
        err_req                          = es;
    end
endmodule

// File: rtl/fpsw_reg_chk.sv
module fpsw_reg_chk
    import fpsw_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_EXC-1:0]  exc_flags,
    input logic                exc_sf,
    input logic [2:0]          cc_kind,
    input logic [INFO_W-1:0]   cc_info,
    input logic                top_we,
    input logic [2:0]          cmd,
    input logic [NUM_EXC-1:0]  exc_mask,
    input logic [WORD_W-1:0]   status_word,
    input logic                err_req
);
    logic rst_seen = 1'b0;

    always @(posedge clk) if (!rst_n) rst_seen <= 1'b1;

    always @(negedge clk) begin
        if (!rst_n && rst_seen)
            assert_reset_zero_R1: assert (status_word == '0 && !err_req);
        if (rst_n) begin
            assert_summary_R3: assert (status_word[ES_BIT] ==
                                       |(status_word[NUM_EXC-1:0] & ~exc_mask));
            assert_copies_R3: assert (status_word[B_BIT] == status_word[ES_BIT]
                                      && err_req == status_word[ES_BIT]);
        end
    end

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd0) |=> ((status_word[NUM_EXC-1:0] & $past(status_word[NUM_EXC-1:0]))
                           == $past(status_word[NUM_EXC-1:0])));

    assert_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_word[NUM_EXC-1:0] & $past(exc_flags)) == $past(exc_flags)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && exc_flags == '0 && !exc_sf) |=> (status_word[SF_BIT:0] == '0));

    assert_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd2 || cmd == 3'd3) && exc_flags == '0 && !exc_sf &&
         cc_kind == 3'd0 && !top_we) |=> (status_word == '0));

    assert_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_kind == 3'd4) |=> (status_word[C2_BIT] == $past(cc_info[0])));

    assert_top_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_we && (cmd == 3'd0 || cmd == 3'd1)) |=> $stable(status_word[C3_BIT-1:TOP_LSB]));
endmodule

bind fpsw_reg fpsw_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_flags   (exc_flags),
    .exc_sf      (exc_sf),
    .cc_kind     (cc_kind),
    .cc_info     (cc_info),
    .top_we      (top_we),
    .cmd         (cmd),
    .exc_mask    (exc_mask),
    .status_word (status_word),
    .err_req     (err_req)
);

// File: tb/fpsw_reg_bench.sv
`timescale 1ns/1ps
module fpsw_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  exc_flags = '0;
    logic        exc_sf = 1'b0;
    logic [2:0]  cc_kind = '0;
    logic [3:0]  cc_info = '0;
    logic        top_we = 1'b0;
    logic [2:0]  top_in = '0;
    logic [2:0]  cmd = '0;
    logic [15:0] load_word = '0;
    logic [5:0]  exc_mask = '1;
    logic [15:0] status_word;
    logic        err_req;

    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;
    logic [15:0] m = '0;

    always #10 clk = ~clk;

    fpsw_reg u_fpsw_reg (
        .clk(clk), .rst_n(rst_n), .exc_flags(exc_flags), .exc_sf(exc_sf),
        .cc_kind(cc_kind), .cc_info(cc_info), .top_we(top_we), .top_in(top_in),
        .cmd(cmd), .load_word(load_word), .exc_mask(exc_mask),
        .status_word(status_word), .err_req(err_req)
    );

    function automatic logic summ(input logic [15:0] w, input logic [5:0] mk);
        return |(w[5:0] & ~mk);
    endfunction

    function automatic logic [15:0] shown(input logic [15:0] w, input logic [5:0] mk);
        logic [15:0] r = w;
        r[7]  = summ(w, mk);
        r[15] = summ(w, mk);
        return r;
    endfunction

    function automatic logic [15:0] model_next(
        input logic [15:0] w, input logic [5:0] ex, input logic sf,
        input logic [2:0] kd, input logic [3:0] inf, input logic [2:0] cm,
        input logic [15:0] ld, input logic twe, input logic [2:0] tin);
        logic [15:0] n = w;
        case (cm)
            3'd1: n[6:0] = '0;
            3'd2, 3'd3: n = '0;
            3'd4: n = ld & 16'h7F7F;
            default: ;
        endcase
        n[5:0] = n[5:0] | ex;
        n[6]   = n[6] | sf;
        case (kd)
            3'd1, 3'd2, 3'd5: n[9] = inf[0];
            3'd3: if (inf[3]) n[10] = 1'b1;
                  else begin n[10] = 1'b0; n[8] = inf[2]; n[14] = inf[1]; n[9] = inf[0]; end
            3'd4: n[10] = inf[0];
            default: ;
        endcase
        if (twe) n[13:11] = tin;
        return n;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive after a falling edge, check the combinational summary at once,
    // then check the stored word at the next falling edge.
    task automatic step(input string tag, input logic [5:0] ex, input logic sf,
                        input logic [2:0] kd, input logic [3:0] inf, input logic [2:0] cm,
                        input logic [15:0] ld, input logic twe, input logic [2:0] tin,
                        input logic [5:0] mk);
        exc_flags = ex; exc_sf = sf; cc_kind = kd; cc_info = inf; cmd = cm;
        load_word = ld; top_we = twe; top_in = tin; exc_mask = mk;
        #1;
        check("R3 err_req", {15'd0, err_req}, {15'd0, summ(m, mk)});
        check("R3 word", status_word, shown(m, mk));
        m = model_next(m, ex, sf, kd, inf, cm, ld, twe, tin);
        @(negedge clk);
        check(tag, status_word, shown(m, mk));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        exc_mask = '0;
        #1;
        check("R1 reset word", status_word, 16'h0000);
        check("R1 reset err_req", {15'd0, err_req}, 16'd0);
        rst_n = 1'b1;

        // R2: report invalid under full mask, no summary
        step("R2 report", 6'b000001, 1'b0, 0, 0, 0, 0, 0, 0, 6'h3F);
        // R3: unmasking raises the summary in the same cycle
        step("R3 unmask", 6'b0, 1'b0, 0, 0, 0, 0, 0, 0, 6'h3E);
        // R2: sticky, plus stack fault
        step("R2 sticky", 6'b100000, 1'b1, 0, 0, 0, 0, 0, 0, 6'h3E);
        // R4: clear with a same-cycle divide-by-zero report
        step("R4 clear+report", 6'b000100, 1'b0, 0, 0, 3'd1, 0, 0, 0, 6'h00);
        // R7: stack overflow then underflow
        step("R7 overflow", 0, 1'b1, 3'd1, 4'h1, 0, 0, 0, 0, 6'h3F);
        step("R7 underflow", 0, 1'b0, 3'd1, 4'h0, 0, 0, 0, 0, 6'h3F);
        // R8: rounding up
        step("R8 round up", 6'b100000, 1'b0, 3'd2, 4'h1, 0, 0, 0, 0, 6'h3F);
        // R9: incomplete then complete with quotient 101
        step("R9 incomplete", 0, 0, 3'd3, 4'b1000, 0, 0, 0, 0, 6'h3F);
        step("R9 complete", 0, 0, 3'd3, 4'b0101, 0, 0, 0, 0, 6'h3F);
        // R10: out of range, then in range
        step("R10 out", 0, 0, 3'd4, 4'h1, 0, 0, 0, 0, 6'h3F);
        step("R10 in", 0, 0, 3'd4, 4'h0, 0, 0, 0, 0, 6'h3F);
        // R11: classify negative, then unused kind 6 leaves codes alone
        step("R11 sign", 0, 0, 3'd5, 4'h1, 0, 0, 0, 0, 6'h3F);
        step("R11 kind6", 0, 0, 3'd6, 4'h0, 0, 0, 0, 0, 6'h3F);
        // R12: stack-top write
        step("R12 top", 0, 0, 0, 0, 0, 0, 1'b1, 3'd5, 6'h3F);
        // R6: load all ones; summary bits recomputed from mask
        step("R6 load masked", 0, 0, 0, 0, 3'd4, 16'hFFFF, 0, 0, 6'h3F);
        step("R6 load unmasked", 0, 0, 0, 0, 3'd4, 16'h0081, 0, 0, 6'h3E);
        // R5: init and save with same-cycle updates
        step("R5 init", 0, 0, 0, 0, 3'd2, 0, 0, 0, 6'h00);
        step("R5 save+report", 6'b010000, 1'b0, 3'd4, 4'h1, 3'd3, 0, 1'b1, 3'd2, 6'h00);

        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  cm = ($urandom % 8 == 0) ? 3'($urandom) : 3'd0;
            logic [5:0]  ex = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
            logic        sf = ($urandom % 16 == 0);
            logic [2:0]  kd = 3'($urandom);
            logic [3:0]  inf = 4'($urandom);
            logic        twe = ($urandom % 8 == 0);
            logic [2:0]  tin = 3'($urandom);
            logic [15:0] ld = 16'($urandom);
            logic [5:0]  mk = ($urandom % 8 == 0) ? 6'($urandom) : exc_mask;
            string tag;
            if (cm == 3'd1) tag = "R4 random";
            else if (cm == 3'd2 || cm == 3'd3) tag = "R5 random";
            else if (cm == 3'd4) tag = "R6 random";
            else if (kd == 3'd1) tag = "R7 random";
            else if (kd == 3'd2) tag = "R8 random";
            else if (kd == 3'd3) tag = "R9 random";
            else if (kd == 3'd4) tag = "R10 random";
            else if (kd == 3'd5) tag = "R11 random";
            else if (twe) tag = "R12 random";
            else tag = "R2 random";
            step(tag, ex, sf, kd, inf, cm, ld, twe, tin, mk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule